// File: doc/BRIEF.md
# Splittable Event Counter Bank

This block holds four physical event counters behind a word-wide register port. Each physical counter either runs as one 32-bit counter or is cut into two independent 16-bit halves, so up to eight logical counters are available. Every logical counter has an event strobe input. While the global run bit is set, a counter advances by one on each cycle its strobe is high. Clearing the run bit freezes all counts.

Software writes to a counter land in a holding latch. They reach the live counter only when the control register is written with the run bit set. This also works as a re-enable while the bank is already running. A read returns the latched value while a write is pending and the bank is stopped; otherwise it returns the live count. A counter or half that wraps from all-ones to zero sets a pending status bit. The interrupt output is raised when any pending bit is also set in the interrupt mask. Reading the status register returns the pending bits and clears them. Each logical counter also has a 32-bit configuration word that software can store and read back.

Top module: `perfBank`

## Requirements
- R1: After reset every register (control, mask, status, counters, latches, configuration words) reads zero and `irq` is low.
- R2: The register map is as follows. Address 0 is control: bit 0 is run, and bit 4+p sets split mode for physical counter p. Address 1 is status on read and the mask on write. Addresses 8+i are logical counter i. Addresses 16+i hold configuration word i, which reads back exactly as written.
- R3: A counter write loads only the holding latch of its physical counter and marks it pending. While run is clear, a read of that counter returns the latched value and the live count is unchanged.
- R4: A control write with bit 0 set copies every pending latch into its live counter and clears all pending marks. On that cycle the commit takes precedence over an event strobe.
- R5: While running, a counter write stays invisible: reads show the live count until the control register is rewritten with run set.
- R6: With run set, a counter advances by one per cycle its strobe is high. With run clear, no counter changes except through a commit.
- R7: In 32-bit mode, physical counter p counts strobe p with full carry across all 32 bits. Strobe 4+p is ignored, and logical address 8+4+p reads and writes the full 32-bit physical counter p.
- R8: In split mode, logical counter p is the upper half of physical counter p and logical counter p+4 is the lower half. Reads are zero-extended. A write replaces only its own half and keeps the other half. No carry passes between the halves.
- R9: A wrap sets a status bit. In 32-bit mode it sets bit p. In split mode the upper half sets bit p and the lower half sets bit p+4. A write to address 1 loads the mask from bits 7:0. `irq` is high exactly when some pending bit is also masked in.
- R10: A status read returns the pending bits and clears them. A wrap on the same cycle as the read stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 8 | Event strobe per logical counter |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears status when reading address 1) |
| addr | input | 5 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first is a commit and a counting event. The bench drives the run-setting control write and a strobe for the pending counter in one cycle. It expects the counter to read exactly the latched value, followed by normal counting from there. The second is a status clear-on-read and a fresh wrap. The bench reads status on the very cycle a 32-bit counter rolls over. The returned word must not contain the new bit, and the next status read must contain it.

// File: rtl/perfBankPkg.sv
package perfBankPkg;
  localparam int PHYS_N    = 4;
  localparam int CNT_W     = 32;
  localparam int HALF_W    = CNT_W / 2;
  localparam int LOG_N     = 2 * PHYS_N;
  localparam int LOG_W     = $clog2(LOG_N);
  localparam int PHYS_W    = $clog2(PHYS_N);
  localparam int ADDR_W    = LOG_W + 2;
  localparam int RUN_BIT   = 0;
  localparam int SPLIT_LSB = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);
  localparam logic [1:0]        PAGE_CNT  = 2'b01;
  localparam logic [1:0]        PAGE_CFG  = 2'b10;

  typedef struct packed {
    logic              runEn;
    logic [PHYS_N-1:0] splitMask;
    logic [PHYS_N-1:0] commitMask;
    logic [PHYS_N-1:0] latchWr;
    logic [CNT_W-1:0]  latchVal;
  } ctlStrobes_t;
endpackage

// File: rtl/perfBankDatapath.sv
module perfBankDatapath
  import perfBankPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strb,
  input  logic [LOG_N-1:0]        evtStrobe,
  output logic [PHYS_N*CNT_W-1:0] liveFlat,
  output logic [PHYS_N*CNT_W-1:0] latchFlat,
  output logic [LOG_N-1:0]        wrapEvt
);
  for (genvar p = 0; p < PHYS_N; p++) begin : gCnt
    logic [CNT_W-1:0] liveQ, latchQ, nextLive;
    logic             countOk, incHi, incLo, hiOnes, loOnes;

    assign countOk = strb.runEn & ~strb.commitMask[p];
    assign incHi   = countOk & evtStrobe[p];
    assign incLo   = countOk & strb.splitMask[p] & evtStrobe[p+PHYS_N];
    assign hiOnes  = &liveQ[CNT_W-1:HALF_W];
    assign loOnes  = &liveQ[HALF_W-1:0];

    // upper half (or whole word) wrap, lower half wrap
    assign wrapEvt[p]        = incHi & hiOnes & (strb.splitMask[p] | loOnes);
    assign wrapEvt[p+PHYS_N] = incLo & loOnes;

    always_comb begin
      nextLive = liveQ;
      if (strb.commitMask[p]) begin
        nextLive = latchQ;
      end else if (strb.splitMask[p]) begin
        nextLive[CNT_W-1:HALF_W] = liveQ[CNT_W-1:HALF_W] + HALF_W'(incHi);
        nextLive[HALF_W-1:0]     = liveQ[HALF_W-1:0] + HALF_W'(incLo);
      end else begin
        nextLive = liveQ + CNT_W'(incHi);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ  <= '0;
        latchQ <= '0;
      end else begin
        liveQ <= nextLive;
        if (strb.latchWr[p]) latchQ <= strb.latchVal;
      end
    end

    assign liveFlat[p*CNT_W +: CNT_W]  = liveQ;
    assign latchFlat[p*CNT_W +: CNT_W] = latchQ;
  end
endmodule

// File: rtl/perfBankCtrl.sv
module perfBankCtrl
  import perfBankPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CNT_W-1:0]        wrData,
  input  logic [PHYS_N*CNT_W-1:0] liveFlat,
  input  logic [PHYS_N*CNT_W-1:0] latchFlat,
  input  logic [LOG_N-1:0]        wrapEvt,
  output ctlStrobes_t             strb,
  output logic [CNT_W-1:0]        rdData,
  output logic [LOG_N-1:0]        statusQ,
  output logic [LOG_N-1:0]        maskQ
);
  logic [CNT_W-1:0]  ctrlQ;
  logic [PHYS_N-1:0] pendQ;
  logic [CNT_W-1:0]  cfgQ [LOG_N];
  logic [CNT_W-1:0]  viewArr [PHYS_N];

  logic              isCtrl, isStat, isCnt, isCfg, upperSel, runNow, doCommit, rdClr;
  logic [LOG_W-1:0]  logIdx;
  logic [PHYS_W-1:0] physIdx;
  logic [CNT_W-1:0]  selView, mergeVal, cntRead;

  assign runNow  = ctrlQ[RUN_BIT];
  assign isCtrl  = (addr == ADDR_CTRL);
  assign isStat  = (addr == ADDR_STAT);
  assign isCnt   = (addr[ADDR_W-1:LOG_W] == PAGE_CNT);
  assign isCfg   = (addr[ADDR_W-1:LOG_W] == PAGE_CFG);
  assign logIdx  = addr[LOG_W-1:0];
  assign physIdx = logIdx[PHYS_W-1:0];
  assign upperSel = (logIdx < LOG_W'(PHYS_N));

  for (genvar p = 0; p < PHYS_N; p++) begin : gView
    assign viewArr[p] = (pendQ[p] && !runNow) ? latchFlat[p*CNT_W +: CNT_W]
                                              : liveFlat[p*CNT_W +: CNT_W];
  end

  assign selView = viewArr[physIdx];

  always_comb begin
    mergeVal = wrData;
    cntRead  = selView;
    if (ctrlQ[SPLIT_LSB + int'(physIdx)]) begin
      if (upperSel) begin
        mergeVal = {wrData[HALF_W-1:0], selView[HALF_W-1:0]};
        cntRead  = CNT_W'(selView[CNT_W-1:HALF_W]);
      end else begin
        mergeVal = {selView[CNT_W-1:HALF_W], wrData[HALF_W-1:0]};
        cntRead  = CNT_W'(selView[HALF_W-1:0]);
      end
    end
  end

  assign doCommit = wrEn && isCtrl && wrData[RUN_BIT];
  assign rdClr    = rdEn && isStat;

  always_comb begin
    strb.runEn      = runNow;
    strb.splitMask  = ctrlQ[SPLIT_LSB +: PHYS_N];
    strb.commitMask = doCommit ? pendQ : '0;
    strb.latchWr    = '0;
    if (wrEn && isCnt) strb.latchWr[physIdx] = 1'b1;
    strb.latchVal   = mergeVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      pendQ   <= '0;
      statusQ <= '0;
      maskQ   <= '0;
      for (int i = 0; i < LOG_N; i++) cfgQ[i] <= '0;
    end else begin
      statusQ <= (rdClr ? '0 : statusQ) | wrapEvt;
      if (wrEn && isCtrl) ctrlQ <= wrData;
      if (wrEn && isStat) maskQ <= wrData[LOG_N-1:0];
      if (wrEn && isCfg)  cfgQ[logIdx] <= wrData;
      if (doCommit)       pendQ <= '0;
      else                pendQ <= pendQ | strb.latchWr;
    end
  end

  always_comb begin
    rdData = '0;
    if (isCtrl)      rdData = ctrlQ;
    else if (isStat) rdData = CNT_W'(statusQ);
    else if (isCnt)  rdData = cntRead;
    else if (isCfg)  rdData = cfgQ[logIdx];
  end
endmodule

// File: rtl/perfBank.sv
module perfBank
  import perfBankPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOG_N-1:0]  evtStrobe,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  ctlStrobes_t             strb;
  logic [PHYS_N*CNT_W-1:0] liveFlat, latchFlat;
  logic [LOG_N-1:0]        wrapEvt, statusQ, maskQ;

  perfBankCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .liveFlat(liveFlat), .latchFlat(latchFlat),
    .wrapEvt(wrapEvt), .strb(strb), .rdData(rdData),
    .statusQ(statusQ), .maskQ(maskQ)
  );

  perfBankDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtStrobe(evtStrobe),
    .liveFlat(liveFlat), .latchFlat(latchFlat), .wrapEvt(wrapEvt)
  );

  assign irq = |(statusQ & maskQ);
endmodule

// File: rtl/perfBankChk.sv
module perfBankChk
  import perfBankPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [LOG_N-1:0]        evtStrobe,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       addr,
  input logic [CNT_W-1:0]        wrData,
  input ctlStrobes_t             strb,
  input logic [PHYS_N*CNT_W-1:0] liveFlat,
  input logic [PHYS_N*CNT_W-1:0] latchFlat,
  input logic [LOG_N-1:0]        wrapEvt,
  input logic [LOG_N-1:0]        statusQ,
  input logic [LOG_N-1:0]        maskQ
);
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runEn && strb.commitMask == '0) |=> $stable(liveFlat));

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_STAT && wrapEvt == '0) |=> statusQ == '0);

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_STAT) |=> maskQ == $past(wrData[LOG_N-1:0]));

  for (genvar i = 0; i < LOG_N; i++) begin : gWrap
    // R9
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrapEvt[i] |=> statusQ[i]);
  end

  for (genvar p = 0; p < PHYS_N; p++) begin : gPhys
    // R4
    commit_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.commitMask[p] |=> liveFlat[p*CNT_W +: CNT_W] == $past(latchFlat[p*CNT_W +: CNT_W]));

    // R8
    no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.splitMask[p] && !strb.commitMask[p] && !evtStrobe[p])
        |=> $stable(liveFlat[p*CNT_W+HALF_W +: HALF_W]));
  end
endmodule

bind perfBank perfBankChk u_chk (.*);

// File: tb/perfBank_tb.sv
module perfBank_tb;
  import perfBankPkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [LOG_N-1:0]  evtStrobe = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [CNT_W-1:0]  rdData;
  logic              irq;

  int checks = 0;
  int failures = 0;
  logic [CNT_W-1:0] got;

  always #4 clk = ~clk;

  perfBank u_dut (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input int a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic regRd(input int a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = ADDR_W'(a);
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [LOG_N-1:0] m, input int n);
    @(negedge clk);
    evtStrobe = m;
    repeat (n) @(posedge clk);
    #1 evtStrobe = '0;
  endtask

  task automatic tReset();
    regRd(0, got);  chk("R1 control", got, 0);
    regRd(1, got);  chk("R1 status", got, 0);
    for (int i = 0; i < LOG_N; i++) begin
      regRd(8 + i, got); chk("R1 counter", got, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic tLatchCommit();
    regWr(8, 100);
    regRd(8, got);  chk("R3 latched read", got, 100);
    pulse(8'h01, 4);
    regRd(8, got);  chk("R3 stopped no count", got, 100);
    regWr(0, 1);
    pulse(8'h01, 5);
    regRd(8, got);  chk("R4 R6 commit then count", got, 105);
    regWr(0, 0);
    pulse(8'h01, 3);
    regRd(8, got);  chk("R6 frozen", got, 105);
  endtask

  task automatic tRunningWrite();
    regWr(0, 1);
    regWr(9, 50);
    regRd(9, got);  chk("R5 live while running", got, 0);
    regWr(0, 1);
    regRd(9, got);  chk("R5 rewrite commits", got, 50);
    pulse(8'h10, 3);
    regRd(8, got);  chk("R7 strobe 4 ignored", got, 105);
    regRd(12, got); chk("R7 alias logical 4", got, 105);
  endtask

  task automatic tSplit();
    regWr(0, 32'h40);
    regWr(10, 32'h1234);
    regWr(14, 32'hFFFE);
    regRd(10, got); chk("R8 upper half", got, 32'h1234);
    regRd(14, got); chk("R8 lower half merged", got, 32'hFFFE);
    regWr(0, 32'h41);
    pulse(8'h40, 2);
    regRd(14, got); chk("R8 lower wrapped", got, 0);
    regRd(10, got); chk("R8 no carry", got, 32'h1234);
    chk("R9 masked off irq", {31'b0, irq}, 0);
    regRd(1, got);  chk("R10 status read", got, 32'h40);
    regRd(1, got);  chk("R10 status cleared", got, 0);
  endtask

  task automatic tIrq();
    regWr(1, 32'h40);
    regWr(0, 32'h40);
    regWr(14, 32'hFFFF);
    regWr(0, 32'h41);
    pulse(8'h40, 1);
    chk("R9 irq raised", {31'b0, irq}, 1);
    regRd(1, got);  chk("R10 status value", got, 32'h40);
    chk("R10 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic tWide();
    regWr(0, 0);
    regWr(8, 32'h0000FFFF);
    regWr(11, 32'hFFFFFFFF);
    regWr(0, 1);
    pulse(8'h01, 1);
    regRd(8, got);  chk("R7 full carry", got, 32'h00010000);
    // status read on the wrap cycle
    @(negedge clk);
    rdEn = 1'b1; addr = ADDR_W'(1); evtStrobe = 8'h08;
    #1 got = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; evtStrobe = '0;
    chk("R10 read before wrap", got, 0);
    regRd(1, got);  chk("R10 wrap kept", got, 32'h08);
    regRd(11, got); chk("R9 wrapped to zero", got, 0);
  endtask

  task automatic tCommitVsEvent();
    regWr(0, 0);
    regWr(9, 10);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(0); wrData = 1; evtStrobe = 8'h02;
    @(posedge clk); #1;
    wrEn = 1'b0; evtStrobe = '0;
    regRd(9, got);  chk("R4 commit beats event", got, 10);
    pulse(8'h02, 1);
    regRd(9, got);  chk("R6 counting resumes", got, 11);
  endtask

  task automatic tCfg();
    regWr(21, 32'hA5A50005);
    regRd(21, got); chk("R2 config readback", got, 32'hA5A50005);
    regRd(20, got); chk("R2 other config", got, 0);
    regRd(0, got);  chk("R2 control readback", got, 1);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tLatchCommit();
    tRunningWrite();
    tSplit();
    tIrq();
    tWide();
    tCommitVsEvent();
    tCfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule